// File: doc/BRIEF.md
# Object and Playfield Pixel Merger

This block holds one scan line of picture in a 256-entry line buffer and builds each final pixel from a playfield layer and up to 64 object layers. First the playfield pixels for the line are written. Then the object pixels are offered one per clock, lowest object index first. Index 0 has the highest priority. Each buffer location keeps a 5-bit colour index and two flags. One flag records that the playfield pixel there is transparent. The other records that some object has already claimed the location.

An object pixel whose 2-bit pattern is non-zero claims its location. It does so even when its colour is not written because a background-priority object sits behind an opaque playfield pixel. After that claim, no later object can appear at that location. Every update is a read-modify-write through a two-stage pipeline, and updates to the same location on back-to-back clocks are forwarded. A separate read port returns the final colour index one clock after the request. Index 0 is the shared backdrop entry.

Top module: `pixel_merge_line`

## Requirements
- R1: After reset, a read of any location returns colour index 0.
- R2: A playfield write stores colour index {0, palette[1:0], pattern[1:0]}. A playfield pixel with pattern 00 is transparent, and a read of that location returns 0 while no object has claimed it.
- R3: An opaque object pixel on an unclaimed location with a transparent playfield pixel is shown as {1, palette[1:0], pattern[1:0]}, whatever its priority bit.
- R4: On an unclaimed location with an opaque playfield pixel, a foreground object pixel (obj_behind=0) replaces the playfield colour. A background object pixel (obj_behind=1) leaves the playfield colour in place.
- R5: An object pixel with pattern 00 changes neither the colour nor the claim, so a later object can still draw at that location.
- R6: The first opaque object pixel at a location claims it even if hidden behind the playfield. No later object pixel changes that location until the next line start.
- R7: line_start releases every claim and keeps the stored colours and playfield flags.
- R8: Updates to the same location on consecutive clocks behave as if applied one after another. This covers an object after an object, an object after a playfield write, and an object right after line_start.
- R9: A read returns its result one clock after rd_valid (out_valid then high). The result includes any update committing on the edge that samples the read.
- R10: At most one of pf_valid, obj_valid and line_start is high in any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Release all object claims for a new line |
| pf_valid | input | 1 | Playfield pixel write |
| pf_x | input | XW | Playfield pixel location |
| pf_pal | input | 2 | Playfield palette select |
| pf_pat | input | 2 | Playfield pattern value (00 transparent) |
| obj_valid | input | 1 | Object pixel merge |
| obj_x | input | XW | Object pixel location |
| obj_pal | input | 2 | Object palette select |
| obj_pat | input | 2 | Object pattern value (00 transparent) |
| obj_behind | input | 1 | 1: object behind opaque playfield |
| rd_valid | input | 1 | Read request |
| rd_x | input | XW | Read location |
| out_valid | output | 1 | Read result valid |
| out_color | output | 5 | Final colour index, 0 = backdrop |

## Verification
Two updates can meet at one location in the same clock. One is the commit of an update in the second stage. The other is the sampling of the next update, or of a read, at that same location. The bench provokes this by issuing an object pixel on the clock after another object pixel, after a playfield write or after line_start at the same location. It also issues a read on the clock right after an update. Each result is judged against the colour index the requirements give when the updates are applied strictly in order.

// File: rtl/pixel_merge_line.sv
module pixel_merge_line #(
  parameter int XW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_start,
  input  logic          pf_valid,
  input  logic [XW-1:0] pf_x,
  input  logic [1:0]    pf_pal,
  input  logic [1:0]    pf_pat,
  input  logic          obj_valid,
  input  logic [XW-1:0] obj_x,
  input  logic [1:0]    obj_pal,
  input  logic [1:0]    obj_pat,
  input  logic          obj_behind,
  input  logic          rd_valid,
  input  logic [XW-1:0] rd_x,
  output logic          out_valid,
  output logic [4:0]    out_color
);
  localparam int N = 1 << XW;

  typedef enum logic [1:0] {OP_NONE, OP_PF, OP_OBJ, OP_CLR} op_e;

  logic [4:0]   col_q [N];
  logic [N-1:0] pftr_q;
  logic [N-1:0] claim_q;

  op_e          in_op, s1_op;
  logic [XW-1:0] in_x, s1_x;
  logic [1:0]   in_pal, in_pat, s1_pal, s1_pat;
  logic         in_behind, s1_behind;
  logic [4:0]   s1_col;
  logic         s1_pftr, s1_claim;

  always_comb begin
    in_op = OP_NONE;
    if (pf_valid) in_op = OP_PF;
    else if (obj_valid) in_op = OP_OBJ;
    else if (line_start) in_op = OP_CLR;
  end

  assign in_x      = pf_valid ? pf_x   : obj_x;
  assign in_pal    = pf_valid ? pf_pal : obj_pal;
  assign in_pat    = pf_valid ? pf_pat : obj_pat;
  assign in_behind = obj_behind;

  logic       s1_wr, obj_opaque, obj_draw;
  logic [4:0] nw_col;
  logic       nw_pftr, nw_claim;

  assign s1_wr      = (s1_op == OP_PF) || (s1_op == OP_OBJ);
  assign obj_opaque = s1_pat != 2'b00;
  assign obj_draw   = obj_opaque && !s1_claim && (s1_pftr || !s1_behind);

  always_comb begin
    nw_col   = s1_col;
    nw_pftr  = s1_pftr;
    nw_claim = s1_claim;
    if (s1_op == OP_PF) begin
      nw_col  = {1'b0, s1_pal, s1_pat};
      nw_pftr = (s1_pat == 2'b00);
    end else if (s1_op == OP_OBJ) begin
      if (obj_draw) nw_col = {1'b1, s1_pal, s1_pat};
      nw_claim = s1_claim | obj_opaque;
    end
  end

  logic       in_hit, rd_hit;
  logic [4:0] f_col, r_col;
  logic       f_pftr, f_claim, r_pftr, r_claim;

  assign in_hit  = s1_wr && (s1_x == in_x);
  assign f_col   = in_hit ? nw_col  : col_q[in_x];
  assign f_pftr  = in_hit ? nw_pftr : pftr_q[in_x];
  assign f_claim = (s1_op == OP_CLR) ? 1'b0 : (in_hit ? nw_claim : claim_q[in_x]);

  assign rd_hit  = s1_wr && (s1_x == rd_x);
  assign r_col   = rd_hit ? nw_col  : col_q[rd_x];
  assign r_pftr  = rd_hit ? nw_pftr : pftr_q[rd_x];
  assign r_claim = (s1_op == OP_CLR) ? 1'b0 : (rd_hit ? nw_claim : claim_q[rd_x]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) col_q[i] <= '0;
      pftr_q    <= '1;
      claim_q   <= '0;
      s1_op     <= OP_NONE;
      s1_x      <= '0;
      s1_pal    <= '0;
      s1_pat    <= '0;
      s1_behind <= 1'b0;
      s1_col    <= '0;
      s1_pftr   <= 1'b1;
      s1_claim  <= 1'b0;
      out_valid <= 1'b0;
      out_color <= '0;
    end else begin
      s1_op     <= in_op;
      s1_x      <= in_x;
      s1_pal    <= in_pal;
      s1_pat    <= in_pat;
      s1_behind <= in_behind;
      s1_col    <= f_col;
      s1_pftr   <= f_pftr;
      s1_claim  <= f_claim;
      if (s1_wr) begin
        col_q[s1_x]   <= nw_col;
        pftr_q[s1_x]  <= nw_pftr;
        claim_q[s1_x] <= nw_claim;
      end
      if (s1_op == OP_CLR) claim_q <= '0;
      out_valid <= rd_valid;
      if (rd_valid) out_color <= (r_pftr && !r_claim) ? 5'd0 : r_col;
    end
  end

  a_r10_one_op: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pf_valid, obj_valid, line_start}));

  a_r9_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> out_valid);

  a_r2_backdrop_code: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_color[1:0] != 2'b00 || out_color == 5'd0));

  a_r2_pf_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_op == OP_PF) |=> pftr_q[$past(s1_x)] == ($past(s1_pat) == 2'b00));

  a_r6_claim_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_op == OP_OBJ && s1_pat != 2'b00) |=> claim_q[$past(s1_x)]);

  a_r6_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_op == OP_OBJ && s1_claim) |=> col_q[$past(s1_x)] == $past(s1_col));

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_op == OP_CLR) |=> claim_q == '0);
endmodule

// File: tb/pixel_merge_line_tb.sv
module pixel_merge_line_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, line_start, pf_valid, obj_valid, obj_behind, rd_valid;
  logic [7:0] pf_x, obj_x, rd_x;
  logic [1:0] pf_pal, pf_pat, obj_pal, obj_pat;
  logic       out_valid;
  logic [4:0] out_color;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  pixel_merge_line #(.XW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_start(line_start),
    .pf_valid(pf_valid), .pf_x(pf_x), .pf_pal(pf_pal), .pf_pat(pf_pat),
    .obj_valid(obj_valid), .obj_x(obj_x), .obj_pal(obj_pal), .obj_pat(obj_pat),
    .obj_behind(obj_behind), .rd_valid(rd_valid), .rd_x(rd_x),
    .out_valid(out_valid), .out_color(out_color));

  task automatic idle_inputs();
    line_start = 0; pf_valid = 0; obj_valid = 0; rd_valid = 0; obj_behind = 0;
    pf_x = 0; obj_x = 0; rd_x = 0; pf_pal = 0; pf_pat = 0; obj_pal = 0; obj_pat = 0;
  endtask

  task automatic check(string req, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pf_px(input int x, input int pal, input int pat);
    @(negedge clk); idle_inputs();
    pf_valid = 1; pf_x = 8'(x); pf_pal = 2'(pal); pf_pat = 2'(pat);
    @(negedge clk); idle_inputs();
  endtask

  task automatic obj_px(input int x, input int pal, input int pat, input bit behind);
    @(negedge clk); idle_inputs();
    obj_valid = 1; obj_x = 8'(x); obj_pal = 2'(pal); obj_pat = 2'(pat); obj_behind = behind;
    @(negedge clk); idle_inputs();
  endtask

  task automatic new_line();
    @(negedge clk); idle_inputs();
    line_start = 1;
    @(negedge clk); idle_inputs();
  endtask

  task automatic rd_chk(input int x, input logic [4:0] exp, input string req);
    @(negedge clk); idle_inputs();
    rd_valid = 1; rd_x = 8'(x);
    @(negedge clk); idle_inputs();
    checks++;
    if (out_valid !== 1'b1) begin
      errors++;
      $display("FAIL %s: out_valid got %0b expected 1", req, out_valid);
    end
    check(req, out_color, exp);
  endtask

  task automatic t_reset();
    rd_chk(0, 5'd0, "R1");
    rd_chk(255, 5'd0, "R1");
  endtask

  task automatic t_playfield();
    pf_px(10, 2, 3);
    rd_chk(10, 5'd11, "R2 opaque pf");
    pf_px(11, 1, 0);
    rd_chk(11, 5'd0, "R2 transparent pf");
  endtask

  task automatic t_obj_on_clear();
    obj_px(11, 3, 2, 0);
    rd_chk(11, 5'd30, "R3 fg on transparent");
    obj_px(22, 2, 1, 1);
    rd_chk(22, 5'd25, "R3 bg on transparent");
  endtask

  task automatic t_priority();
    pf_px(20, 1, 1);
    obj_px(20, 0, 3, 0);
    rd_chk(20, 5'd19, "R4 fg over pf");
    pf_px(21, 1, 2);
    obj_px(21, 2, 1, 1);
    rd_chk(21, 5'd6, "R4 bg behind pf");
  endtask

  task automatic t_claim();
    obj_px(21, 3, 3, 0);
    rd_chk(21, 5'd6, "R6 hidden claim blocks later fg");
    obj_px(22, 1, 1, 0);
    rd_chk(22, 5'd25, "R6 drawn claim blocks later");
  endtask

  task automatic t_transparent_obj();
    obj_px(30, 3, 0, 0);
    rd_chk(30, 5'd0, "R5 transparent obj no colour");
    obj_px(30, 1, 1, 0);
    rd_chk(30, 5'd21, "R5 later obj still draws");
  endtask

  task automatic t_new_line();
    new_line();
    rd_chk(21, 5'd6, "R7 colour kept");
    obj_px(21, 3, 3, 0);
    rd_chk(21, 5'd31, "R7 claim released");
  endtask

  task automatic t_back_to_back();
    new_line();
    @(negedge clk); idle_inputs();
    obj_valid = 1; obj_x = 40; obj_pal = 1; obj_pat = 1;
    @(negedge clk); idle_inputs();
    obj_valid = 1; obj_x = 40; obj_pal = 2; obj_pat = 2;
    @(negedge clk); idle_inputs();
    rd_chk(40, 5'd21, "R8 obj after obj");
    @(negedge clk); idle_inputs();
    pf_valid = 1; pf_x = 41; pf_pal = 1; pf_pat = 3;
    @(negedge clk); idle_inputs();
    obj_valid = 1; obj_x = 41; obj_pal = 2; obj_pat = 2; obj_behind = 1;
    @(negedge clk); idle_inputs();
    rd_chk(41, 5'd7, "R8 obj after pf");
    @(negedge clk); idle_inputs();
    line_start = 1;
    @(negedge clk); idle_inputs();
    obj_valid = 1; obj_x = 40; obj_pal = 3; obj_pat = 1;
    @(negedge clk); idle_inputs();
    rd_chk(40, 5'd29, "R8 obj after line_start");
  endtask

  task automatic t_read_same_cycle();
    @(negedge clk); idle_inputs();
    obj_valid = 1; obj_x = 50; obj_pal = 0; obj_pat = 2;
    @(negedge clk); idle_inputs();
    rd_valid = 1; rd_x = 50;
    @(negedge clk); idle_inputs();
    checks++;
    if (out_valid !== 1'b1) begin
      errors++;
      $display("FAIL R9: out_valid got %0b expected 1", out_valid);
    end
    check("R9 read during commit", out_color, 5'd18);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R9: out_valid got %0b expected 0", out_valid);
    end
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_playfield();
    t_obj_on_clear();
    t_priority();
    t_claim();
    t_transparent_obj();
    t_new_line();
    t_back_to_back();
    t_read_same_cycle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule